// File: doc/BRIEF.md
# Single-Wire EEPROM Master Sequencer

This block drives the master side of a single-wire serial EEPROM bus, one byte action at a time. A client hands it one request: a plain command, a write-type command, a status read, or an address probe. The sequencer then issues the bus actions that the request needs, one after another, to a bit-level line engine. The actions are a standby pulse or a short setup delay, the start header, the device address, the command byte, the operand bytes, byte reads, and the master acknowledge bit. After each address, command, operand or acknowledge action it checks whether the slave acknowledged. If the slave did not, it abandons the command.

The sequencer remembers the last device it talked to and whether that exchange closed cleanly. It uses this to choose between the long standby pulse and the short header setup delay. When a write-type command closes cleanly, the sequencer opens a status read on the same device straight away. It keeps re-reading the status byte until the write-in-progress flag drops, or until a configurable number of reads has been spent. A one-cycle completion pulse reports the result code and the last status byte read.

Top module: `swq_top`

## Requirements
- R1: After reset, req_ready is 1 and bus_valid and done are 0. The first command after reset opens with a standby pulse. Action kinds on bus_kind are: 0 standby, 1 setup delay, 2 header, 3 transmit byte, 4 receive byte, 5 master acknowledge bit.
- R2: A plain or write-type command issues these actions in order: preamble, header, device byte with MAK, command byte, then req_len operand bytes taken from wr_byte. Each byte carries MAK except the last byte of the command, which carries NoMAK (bus_mak 0).
- R3: When the slave does not acknowledge a transmit or acknowledge action, the command stops with no further bus action and done_code 1. The next command opens with a standby pulse.
- R4: A command opens with the setup delay instead of a standby pulse only when the previous command went to the same device and did not end with done_code 1.
- R5: A command to a device other than the previous one opens with a standby pulse.
- R6: Once a write-type command (req_op 1) closes cleanly, the next actions are a setup delay, header, device byte with MAK, and the status-read code 0x05 with MAK. Each receive action is followed by an acknowledge action.
- R7: During polling, while bit 0 (write-in-progress) of a received status byte is 1, the acknowledge bit is MAK and the status is read again. When bit 0 is 0, the bit is NoMAK and done_code is 0.
- R8: If bit 0 is still 1 in read number POLL_MAX, NoMAK is sent and done_code is 2. This outcome leaves the device history clean.
- R9: An address probe (req_op 3) always opens with a standby pulse, then sends the header and the device byte with NoMAK. done_code is 0 if the slave acknowledged the device byte and 1 if it did not.
- R10: A status read (req_op 2) sends the device byte and 0x05 with MAK, receives one byte, and ends with NoMAK. done_data returns the received byte.
- R11: req_ready is 0 from the accepting edge until done. done lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_op | input | 2 | 0 plain, 1 write-type, 2 status read, 3 probe |
| req_dev | input | BYTE_W | Device address byte |
| req_cmd | input | BYTE_W | Command byte for ops 0 and 1 |
| req_len | input | LEN_W | Operand byte count for ops 0 and 1 |
| wr_byte | input | BYTE_W | Current operand byte |
| wr_take | output | 1 | Pulse: wr_byte consumed, present the next one |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 2 | 0 ok, 1 no acknowledge, 2 poll timeout |
| done_data | output | BYTE_W | Last status byte received |
| bus_valid | output | 1 | Byte action requested from the line engine |
| bus_kind | output | 3 | Action kind (see R1) |
| bus_tx | output | BYTE_W | Byte to transmit |
| bus_mak | output | 1 | Acknowledge bit to send (1 MAK, 0 NoMAK) |
| bus_done | input | 1 | Line engine finished the action |
| bus_sak | input | 1 | Slave acknowledge seen for the action |
| bus_rx | input | BYTE_W | Byte received by a receive action |

## Verification
The one-cycle overlap that matters is at the end of a write-type command. There, the close of the write and the start of polling happen in the same cycle. The same is true when a poll read's write-in-progress flag is evaluated in the very read that reaches the poll limit. The bench provokes the first case with a write that has no operands and a status that is already idle. It provokes the second by setting the scripted busy-read count to exactly one less than the limit, and then exactly equal to it. The results are judged from the order of the logged actions and their acknowledge bits, and from the completion code.

// File: rtl/swq_pkg.sv
package swq_pkg;
  typedef enum logic [2:0] {
    BK_STBY  = 3'd0,
    BK_SETUP = 3'd1,
    BK_HDR   = 3'd2,
    BK_TX    = 3'd3,
    BK_RX    = 3'd4,
    BK_ACK   = 3'd5
  } bus_kind_e;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_WRITE = 2'd1,
    OP_STAT  = 2'd2,
    OP_PROBE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RC_OK   = 2'd0,
    RC_NACK = 2'd1,
    RC_TMO  = 2'd2
  } rc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_HDR, ST_DEV, ST_CMD, ST_OPND, ST_RD, ST_ACK
  } st_e;
endpackage

// File: rtl/swq_history.sv
module swq_history #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [BYTE_W-1:0] upd_dev,
  input  logic              upd_clean,
  input  logic [BYTE_W-1:0] q_dev,
  input  logic              q_force,
  output logic              need_stby
);
  logic [BYTE_W-1:0] last_dev;
  logic              clean;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_dev <= '0;
      clean    <= 1'b0;
    end else if (upd) begin
      last_dev <= upd_dev;
      clean    <= upd_clean;
    end
  end

  // a standby pulse is needed unless the same device closed cleanly last time
  assign need_stby = q_force | ~clean | (q_dev != last_dev);
endmodule

// File: rtl/swq_poll_ctr.sv
module swq_poll_ctr #(
  parameter int POLL_MAX = 8,
  localparam int CW = (POLL_MAX > 2) ? $clog2(POLL_MAX) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam logic [CW-1:0] LAST = CW'(POLL_MAX - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && !at_limit) cnt <= cnt + 1'b1;
  end

  // reads already spent equals POLL_MAX-1: the read being judged is the last one
  assign at_limit = (cnt == LAST);
endmodule

// File: rtl/swq_top.sv
module swq_top
  import swq_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter int          LEN_W     = 4,
  parameter int          POLL_MAX  = 8,
  parameter int          WIP_BIT   = 0,
  parameter logic [7:0]  RDSR_CODE = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [BYTE_W-1:0] req_dev,
  input  logic [BYTE_W-1:0] req_cmd,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              wr_take,
  output logic              done,
  output logic [1:0]        done_code,
  output logic [BYTE_W-1:0] done_data,
  output logic              bus_valid,
  output logic [2:0]        bus_kind,
  output logic [BYTE_W-1:0] bus_tx,
  output logic              bus_mak,
  input  logic              bus_done,
  input  logic              bus_sak,
  input  logic [BYTE_W-1:0] bus_rx
);
  localparam logic [BYTE_W-1:0] RDSR_B = BYTE_W'(RDSR_CODE);

  st_e               st, nxt_c;
  op_e               op_q;
  logic [BYTE_W-1:0] dev_q, cmd_q, rx_q;
  logic [LEN_W-1:0]  left_q;
  logic              pend, polling, amak_q, amak_c;
  rc_e               acode_q, acode_c, fin_code_c;
  logic              fin_c, cmd_end_c, dec_c, inc_c, poll_set_c;
  logic              hist_upd, hist_clean, need_stby, at_limit;
  logic              ev;
  bus_kind_e         iss_kind;
  logic [BYTE_W-1:0] iss_byte;
  logic              iss_mak;

  assign ev = pend & bus_done;

  swq_history #(.BYTE_W(BYTE_W)) hist_i (
    .clk(clk), .rst(rst), .upd(hist_upd), .upd_dev(dev_q),
    .upd_clean(hist_clean), .q_dev(dev_q), .q_force(op_q == OP_PROBE),
    .need_stby(need_stby)
  );

  swq_poll_ctr #(.POLL_MAX(POLL_MAX)) poll_i (
    .clk(clk), .rst(rst), .clr(poll_set_c), .inc(inc_c), .at_limit(at_limit)
  );

  // action to issue for the current state
  always_comb begin
    iss_kind = BK_HDR;
    iss_byte = '0;
    iss_mak  = 1'b0;
    unique case (st)
      ST_PRE:  iss_kind = (!polling && need_stby) ? BK_STBY : BK_SETUP;
      ST_HDR:  iss_kind = BK_HDR;
      ST_DEV: begin
        iss_kind = BK_TX;
        iss_byte = dev_q;
        iss_mak  = (op_q != OP_PROBE);
      end
      ST_CMD: begin
        iss_kind = BK_TX;
        if (polling || op_q == OP_STAT) begin
          iss_byte = RDSR_B;
          iss_mak  = 1'b1;
        end else begin
          iss_byte = cmd_q;
          iss_mak  = (left_q != '0);
        end
      end
      ST_OPND: begin
        iss_kind = BK_TX;
        iss_byte = wr_byte;
        iss_mak  = (left_q != LEN_W'(1));
      end
      ST_RD:   iss_kind = BK_RX;
      ST_ACK: begin
        iss_kind = BK_ACK;
        iss_mak  = amak_q;
      end
      default: iss_kind = BK_HDR;
    endcase
  end

  // reaction to a finished action
  always_comb begin
    nxt_c      = st;
    fin_c      = 1'b0;
    fin_code_c = RC_OK;
    cmd_end_c  = 1'b0;
    dec_c      = 1'b0;
    inc_c      = 1'b0;
    poll_set_c = 1'b0;
    amak_c     = amak_q;
    acode_c    = acode_q;
    if (ev) begin
      unique case (st)
        ST_PRE: nxt_c = ST_HDR;
        ST_HDR: nxt_c = ST_DEV;
        ST_DEV: begin
          if (!bus_sak) begin
            fin_c = 1'b1; fin_code_c = RC_NACK;
          end else if (op_q == OP_PROBE) begin
            fin_c = 1'b1;
          end else begin
            nxt_c = ST_CMD;
          end
        end
        ST_CMD: begin
          if (!bus_sak) begin
            fin_c = 1'b1; fin_code_c = RC_NACK;
          end else if (polling || op_q == OP_STAT) begin
            nxt_c = ST_RD;
          end else if (left_q != '0) begin
            nxt_c = ST_OPND;
          end else begin
            cmd_end_c = 1'b1;
          end
        end
        ST_OPND: begin
          if (!bus_sak) begin
            fin_c = 1'b1; fin_code_c = RC_NACK;
          end else begin
            dec_c = 1'b1;
            if (left_q == LEN_W'(1)) cmd_end_c = 1'b1;
            else nxt_c = ST_OPND;
          end
        end
        ST_RD: begin
          nxt_c = ST_ACK;
          if (!polling) begin
            amak_c = 1'b0; acode_c = RC_OK;
          end else if (!bus_rx[WIP_BIT]) begin
            amak_c = 1'b0; acode_c = RC_OK;
          end else if (at_limit) begin
            amak_c = 1'b0; acode_c = RC_TMO;
          end else begin
            amak_c = 1'b1; acode_c = RC_OK; inc_c = 1'b1;
          end
        end
        ST_ACK: begin
          if (!bus_sak) begin
            fin_c = 1'b1; fin_code_c = RC_NACK;
          end else if (amak_q) begin
            nxt_c = ST_RD;
          end else begin
            fin_c = 1'b1; fin_code_c = acode_q;
          end
        end
        default: nxt_c = ST_IDLE;
      endcase
      if (cmd_end_c) begin
        if (op_q == OP_WRITE) begin
          poll_set_c = 1'b1;
          nxt_c      = ST_PRE;
        end else begin
          fin_c = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      pend       <= 1'b0;
      polling    <= 1'b0;
      op_q       <= OP_CMD;
      dev_q      <= '0;
      cmd_q      <= '0;
      left_q     <= '0;
      rx_q       <= '0;
      amak_q     <= 1'b0;
      acode_q    <= RC_OK;
      req_ready  <= 1'b1;
      done       <= 1'b0;
      done_code  <= '0;
      done_data  <= '0;
      wr_take    <= 1'b0;
      bus_valid  <= 1'b0;
      bus_kind   <= '0;
      bus_tx     <= '0;
      bus_mak    <= 1'b0;
      hist_upd   <= 1'b0;
      hist_clean <= 1'b0;
    end else begin
      done     <= 1'b0;
      wr_take  <= 1'b0;
      hist_upd <= 1'b0;
      if (st == ST_IDLE) begin
        if (req_valid && req_ready) begin
          op_q      <= op_e'(req_op);
          dev_q     <= req_dev;
          cmd_q     <= req_cmd;
          left_q    <= req_len;
          rx_q      <= '0;
          polling   <= 1'b0;
          req_ready <= 1'b0;
          st        <= ST_PRE;
        end
      end else if (!pend) begin
        pend      <= 1'b1;
        bus_valid <= 1'b1;
        bus_kind  <= iss_kind;
        bus_tx    <= iss_byte;
        bus_mak   <= iss_mak;
        if (st == ST_OPND) wr_take <= 1'b1;
      end else if (bus_done) begin
        pend      <= 1'b0;
        bus_valid <= 1'b0;
        amak_q    <= amak_c;
        acode_q   <= acode_c;
        if (st == ST_RD) rx_q <= bus_rx;
        if (dec_c) left_q <= left_q - 1'b1;
        if (poll_set_c) polling <= 1'b1;
        if (fin_c) begin
          st         <= ST_IDLE;
          done       <= 1'b1;
          done_code  <= fin_code_c;
          done_data  <= rx_q;
          req_ready  <= 1'b1;
          hist_upd   <= 1'b1;
          hist_clean <= (fin_code_c != RC_NACK);
        end else begin
          st <= nxt_c;
        end
      end
    end
  end
endmodule

// File: rtl/swq_chk.sv
module swq_chk
  import swq_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              done,
  input logic [1:0]        done_code,
  input logic              bus_valid,
  input logic [2:0]        bus_kind,
  input logic [BYTE_W-1:0] bus_tx,
  input logic              bus_mak,
  input logic              bus_done
);
  logic vq, err_q, new_act;

  assign new_act = bus_valid & ~vq;

  always_ff @(posedge clk) begin
    if (rst) begin
      vq    <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vq <= bus_valid;
      if (done && done_code == RC_NACK) err_q <= 1'b1;
      else if (new_act && bus_kind == BK_STBY) err_q <= 1'b0;
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !bus_valid);

  // R2
  action_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_done |=> bus_valid && $stable(bus_kind) && $stable(bus_tx) && $stable(bus_mak));

  // R3
  err_stby_chk: assert property (@(posedge clk) disable iff (rst)
    new_act && (bus_kind == BK_SETUP || bus_kind == BK_HDR) |-> !err_q);

  // R8
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> done_code != 2'd3);
endmodule

bind swq_top swq_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst(rst), .req_ready(req_ready), .done(done),
  .done_code(done_code), .bus_valid(bus_valid), .bus_kind(bus_kind),
  .bus_tx(bus_tx), .bus_mak(bus_mak), .bus_done(bus_done)
);

// File: tb/swq_top_tb.sv
`timescale 1ns/1ps
module swq_top_tb_top;
  localparam int BW = 8;
  localparam int LW = 4;
  localparam int PM = 8;
  localparam logic [7:0] BASE = 8'h0C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [BW-1:0] req_dev = '0, req_cmd = '0;
  logic [LW-1:0] req_len = '0;
  logic [BW-1:0] wr_byte = '0;
  logic wr_take, done;
  logic [1:0] done_code;
  logic [BW-1:0] done_data;
  logic bus_valid;
  logic [2:0] bus_kind;
  logic [BW-1:0] bus_tx;
  logic bus_mak;
  logic bus_done = 1'b0, bus_sak = 1'b0;
  logic [BW-1:0] bus_rx = '0;

  int checks = 0, errors = 0;
  logic [11:0] exp_q[$];
  logic [BW-1:0] opnd[8];
  int opnd_idx = 0, act_idx = 0, nack_at = -1, wip_left = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  swq_top #(.BYTE_W(BW), .LEN_W(LW), .POLL_MAX(PM)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_dev(req_dev), .req_cmd(req_cmd), .req_len(req_len),
    .wr_byte(wr_byte), .wr_take(wr_take), .done(done), .done_code(done_code),
    .done_data(done_data), .bus_valid(bus_valid), .bus_kind(bus_kind),
    .bus_tx(bus_tx), .bus_mak(bus_mak), .bus_done(bus_done), .bus_sak(bus_sak),
    .bus_rx(bus_rx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver side: expected actions {kind, mak, byte}
  task automatic ex(input logic [2:0] k, input logic [7:0] b, input logic m);
    exp_q.push_back({k, m, b});
  endtask
  task automatic ex_head(input logic stby, input logic [7:0] dev, input logic dmak);
    ex(stby ? 3'd0 : 3'd1, 8'h00, 1'b0);
    ex(3'd2, 8'h00, 1'b0);
    ex(3'd3, dev, dmak);
  endtask
  task automatic ex_reads(input int n);
    for (int i = 0; i < n; i++) begin
      ex(3'd4, 8'h00, 1'b0);
      ex(3'd5, 8'h00, (i < n - 1));
    end
  endtask
  task automatic ex_poll(input logic [7:0] dev, input int n);
    ex_head(1'b0, dev, 1'b1);
    ex(3'd3, 8'h05, 1'b1);
    ex_reads(n);
  endtask

  // line-engine model and monitor
  initial begin
    int cnt;
    int cur_idx;
    logic active;
    logic [2:0] cur_kind;
    active = 1'b0;
    cnt = 0;
    cur_idx = 0;
    cur_kind = '0;
    forever begin
      @(negedge clk);
      if (wr_take) begin
        opnd_idx++;
        wr_byte = opnd[opnd_idx % 8];
      end
      if (bus_done) begin
        bus_done = 1'b0;
      end else if (active) begin
        cnt--;
        if (cnt == 0) begin
          active = 1'b0;
          bus_sak = (cur_idx != nack_at);
          if (cur_kind == 3'd4) begin
            bus_rx = BASE | ((wip_left > 0) ? 8'h01 : 8'h00);
            if (wip_left > 0) wip_left--;
          end
          bus_done = 1'b1;
        end
      end else if (bus_valid && !rst) begin
        active = 1'b1;
        cnt = 2;
        cur_idx = act_idx;
        act_idx++;
        cur_kind = bus_kind;
        if (exp_q.size() == 0) begin
          chk({cur_req, " unexpected action"}, {20'h0, bus_kind, bus_mak, bus_tx}, 32'hFFFF);
        end else begin
          chk({cur_req, " action"}, {20'h0, bus_kind, bus_mak, bus_tx}, {20'h0, exp_q.pop_front()});
        end
      end
    end
  end

  task automatic run(input logic [1:0] op, input logic [7:0] dev, input logic [7:0] cmd,
                     input int n, input int nack, input int wip,
                     input logic [1:0] ecode, input logic [7:0] edata, input string req);
    int guard;
    cur_req = req;
    act_idx = 0;
    nack_at = nack;
    wip_left = wip;
    opnd_idx = 0;
    wr_byte = opnd[0];
    @(negedge clk);
    req_op = op; req_dev = dev; req_cmd = cmd; req_len = LW'(n);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R11: busy once accepted
    chk("R11 ready low", {31'h0, req_ready}, 32'h0);
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (!done) begin
      chk({req, " watchdog"}, 32'h1, 32'h0);
    end else begin
      chk({req, " code"}, {30'h0, done_code}, {30'h0, ecode});
      chk({req, " data"}, {24'h0, done_data}, {24'h0, edata});
      chk({req, " all actions seen"}, exp_q.size(), 0);
      exp_q.delete();
      @(negedge clk);
      chk("R11 done one cycle", {31'h0, done}, 32'h0);
      chk("R11 ready back", {31'h0, req_ready}, 32'h1);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) opnd[i] = 8'h30 + 8'(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'h0, req_ready}, 32'h1);
    chk("R1 bus_valid", {31'h0, bus_valid}, 32'h0);
    chk("R1 done", {31'h0, done}, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R2: first command after reset opens with standby, no operands
    ex_head(1'b1, 8'hA0, 1'b1); ex(3'd3, 8'h96, 1'b0);
    run(2'd0, 8'hA0, 8'h96, 0, -1, 0, 2'd0, 8'h00, "R2");

    // R4 R6 R7: write with three operands, then four status reads
    ex_head(1'b0, 8'hA0, 1'b1); ex(3'd3, 8'h6C, 1'b1);
    ex(3'd3, 8'h30, 1'b1); ex(3'd3, 8'h31, 1'b1); ex(3'd3, 8'h32, 1'b0);
    ex_poll(8'hA0, 4);
    run(2'd1, 8'hA0, 8'h6C, 3, -1, 3, 2'd0, BASE, "R7");

    // R5 R10: status read on another device
    ex_head(1'b1, 8'hA1, 1'b1); ex(3'd3, 8'h05, 1'b1); ex_reads(1);
    run(2'd2, 8'hA1, 8'h00, 0, -1, 0, 2'd0, BASE, "R10");

    // R8: busy in every read up to the limit
    ex_head(1'b0, 8'hA1, 1'b1); ex(3'd3, 8'h6C, 1'b1); ex(3'd3, 8'h30, 1'b0);
    ex_poll(8'hA1, PM);
    run(2'd1, 8'hA1, 8'h6C, 1, -1, PM, 2'd2, BASE | 8'h01, "R8");

    // R8 R4: idle exactly in the last allowed read; history still clean
    ex_head(1'b0, 8'hA1, 1'b1); ex(3'd3, 8'h6C, 1'b1); ex(3'd3, 8'h30, 1'b0);
    ex_poll(8'hA1, PM);
    run(2'd1, 8'hA1, 8'h6C, 1, -1, PM - 1, 2'd0, BASE, "R8");

    // R3: no acknowledge on the command byte aborts
    ex_head(1'b0, 8'hA1, 1'b1); ex(3'd3, 8'h55, 1'b1);
    run(2'd0, 8'hA1, 8'h55, 2, 3, 0, 2'd1, 8'h00, "R3");

    // R3: after the error the same device needs a standby pulse
    ex_head(1'b1, 8'hA1, 1'b1); ex(3'd3, 8'h05, 1'b1); ex_reads(1);
    run(2'd2, 8'hA1, 8'h00, 0, -1, 0, 2'd0, BASE, "R3");

    // R9: probe of a present device, standby even though history is clean
    ex_head(1'b1, 8'hA1, 1'b0);
    run(2'd3, 8'hA1, 8'h00, 0, -1, 0, 2'd0, 8'h00, "R9");

    // R9: probe of an absent device
    ex_head(1'b1, 8'hA2, 1'b0);
    run(2'd3, 8'hA2, 8'h00, 0, 2, 0, 2'd1, 8'h00, "R9");

    // R3 R6: operand-free write right after the failed probe, idle at once
    ex_head(1'b1, 8'hA2, 1'b1); ex(3'd3, 8'h67, 1'b0);
    ex_poll(8'hA2, 1);
    run(2'd1, 8'hA2, 8'h67, 0, -1, 0, 2'd0, BASE, "R6");

    // R7: no acknowledge on a poll MAK bit aborts with code 1
    ex_head(1'b0, 8'hA2, 1'b1); ex(3'd3, 8'h67, 1'b0);
    ex_head(1'b0, 8'hA2, 1'b1); ex(3'd3, 8'h05, 1'b1);
    ex(3'd4, 8'h00, 1'b0); ex(3'd5, 8'h00, 1'b1);
    run(2'd1, 8'hA2, 8'h67, 0, 9, 3, 2'd1, BASE | 8'h01, "R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule